// File: doc/BRIEF.md
# Platform Status and Control Register Bank

This block is a small bank of 32-bit registers that sits in a 4 KB window of the system address map. Software reads it to learn fixed facts about the platform: identifier words, memory health, the clock divider set-up and the build configuration. It also writes it to ask for a full system reset. Two live inputs feed the read values. One gives the timer clock frequency in MHz and the other gives the installed memory size in GiB. Every other read value is a constant encoding.

An access is presented for one cycle on `req_valid`, together with the direction, the address, a size code and the write data. All results are registered. One cycle after the request, the bank shows read data with `rd_valid`, a one-cycle `unimpl` flag when the access was not honoured, and a one-cycle `sys_reset_req` pulse when the reset bit was written. The reset controller that consumes the pulse, the clock generator and the memory calibration logic live outside this block.

Size code encoding on `req_size`: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes and 3 is 8 bytes.

Top module: `plat_ctrl_regs`

## Requirements
- R1: Only size code 2 (4 bytes) is honoured. A read with any other size returns zero, a write with any other size is dropped and issues no reset, and in both cases `unimpl` is raised.
- R2: 4-byte reads of offsets 0x00, 0x04 and 0x08 (identifier words) return zero with `unimpl` low.
- R3: A 4-byte read of offset 0x14 (memory status) returns 0x00000005: bit 0 is locked, bit 2 is calibrated, and all other bits are clear.
- R4: A 4-byte read of offset 0x30 (clock divider) returns the following fields: [31:24]=1, [23:16]=1 (multiplier), [15:8]=`timer_mhz` and [7:0]=1.
- R5: A 4-byte read of offset 0x34 (build configuration) returns 0x0000000E: bits 1 to 3 (link enables) are set and bit 0 (coherence unit) is clear.
- R6: A 4-byte read of offset 0x38 (memory configuration) returns `mem_gib` in [3:0], ones in [15:4] and zero in [31:16].
- R7: A 4-byte write to offset 0x10 with data bit 4 set raises `sys_reset_req` for exactly one cycle, in the cycle after the request.
- R8: A 4-byte write to offset 0x10 with data bit 4 clear gives no reset pulse and no `unimpl`.
- R9: 4-byte writes to offsets 0x00, 0x04, 0x08, 0x14, 0x18, 0x30, 0x34 and 0x38 are ignored without `unimpl`, and later reads of those offsets are unchanged.
- R10: Any other offset is undecoded, and so are reads of 0x10 and 0x18. Reads of these return zero, writes are dropped, and both raise `unimpl`.
- R11: Decode uses only address bits [15:0]. Higher address bits do not change the result.
- R12: `rd_valid`, `rdata` and `unimpl` are registered and appear in the cycle after the request. `rd_valid` is high exactly one cycle per read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request, one cycle per access |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | ADDR_W (32) | Byte address; bits [15:0] are decoded |
| req_size | input | 2 | Size code: 0 is 1 B, 1 is 2 B, 2 is 4 B, 3 is 8 B |
| req_wdata | input | 32 | Write data |
| timer_mhz | input | MHZ_W (8) | Timer clock frequency in MHz |
| mem_gib | input | GIB_W (4) | Memory size in GiB |
| rdata | output | 32 | Registered read data |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| unimpl | output | 1 | One-cycle flag: the access was not honoured |
| sys_reset_req | output | 1 | One-cycle system reset request |

## Verification
If the decode state goes wrong, the fault appears in the very next cycle: a read returns the value of a neighbouring register, or `unimpl` is flagged on an offset that should be ignored quietly. A reset trigger that latched instead of pulsing would hold `sys_reset_req` high through the idle cycle that follows a trigger. A trigger that ignored the size or data bit would pulse after a dropped or no-op write. Live-field errors show only when the inputs change between reads, so both inputs are moved during the run and the boundary memory size of 15 GiB is read back.

// File: rtl/plat_regs_pkg.sv
// Shared types and constants of the platform register bank.
// Assumes a 32-bit data path and a 16-bit decoded offset.
package plat_regs_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } acc_size_e;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_ID0,
        SEL_ID1,
        SEL_ID2,
        SEL_RSTCTL,
        SEL_MEMSTAT,
        SEL_LINKSTAT,
        SEL_CLKDIV,
        SEL_BUILDCFG,
        SEL_MEMCFG
    } reg_sel_e;

    localparam int DATA_W  = 32;
    localparam int OFF_W   = 16;
    localparam int FIELD_W = 8;

    localparam logic [OFF_W-1:0] OFF_ID0      = 16'h0000;
    localparam logic [OFF_W-1:0] OFF_ID1      = 16'h0004;
    localparam logic [OFF_W-1:0] OFF_ID2      = 16'h0008;
    localparam logic [OFF_W-1:0] OFF_RSTCTL   = 16'h0010;
    localparam logic [OFF_W-1:0] OFF_MEMSTAT  = 16'h0014;
    localparam logic [OFF_W-1:0] OFF_LINKSTAT = 16'h0018;
    localparam logic [OFF_W-1:0] OFF_CLKDIV   = 16'h0030;
    localparam logic [OFF_W-1:0] OFF_BUILDCFG = 16'h0034;
    localparam logic [OFF_W-1:0] OFF_MEMCFG   = 16'h0038;

    localparam int RST_BIT = 4;

    localparam logic [DATA_W-1:0] MEMSTAT_VAL  = 32'h0000_0005;
    localparam logic [DATA_W-1:0] BUILDCFG_VAL = 32'h0000_000E;

endpackage

// File: rtl/plat_addr_decode.sv
// Offset decoder: maps a decoded offset to a register select and tells
// whether that offset is implemented for reads and for writes.
// Purely combinational; assumes the caller has already cut the address.
module plat_addr_decode
    import plat_regs_pkg::*;
#(
    parameter int DEC_W = OFF_W
) (
    input  logic [DEC_W-1:0] offset,
    output reg_sel_e         sel,
    output logic             rd_known,
    output logic             wr_known
);

    // Select the register addressed by the offset.
    always_comb begin
        case (offset)
            OFF_ID0:      sel = SEL_ID0;
            OFF_ID1:      sel = SEL_ID1;
            OFF_ID2:      sel = SEL_ID2;
            OFF_RSTCTL:   sel = SEL_RSTCTL;
            OFF_MEMSTAT:  sel = SEL_MEMSTAT;
            OFF_LINKSTAT: sel = SEL_LINKSTAT;
            OFF_CLKDIV:   sel = SEL_CLKDIV;
            OFF_BUILDCFG: sel = SEL_BUILDCFG;
            OFF_MEMCFG:   sel = SEL_MEMCFG;
            default:      sel = SEL_NONE;
        endcase
    end

    // Reads are implemented everywhere except the control and link words.
    always_comb begin
        case (sel)
            SEL_NONE, SEL_RSTCTL, SEL_LINKSTAT: rd_known = 1'b0;
            default:                            rd_known = 1'b1;
        endcase
    end

    // Writes are accepted (stored nowhere) by every named register.
    always_comb wr_known = (sel != SEL_NONE);

endmodule

// File: rtl/plat_status_mux.sv
// Read value composer: builds the 32-bit word of each readable register
// from fixed encodings and the two live inputs.
// Assumes input widths do not exceed their field widths.
module plat_status_mux
    import plat_regs_pkg::*;
#(
    parameter int MHZ_W = 8,
    parameter int GIB_W = 4
) (
    input  reg_sel_e          sel,
    input  logic [MHZ_W-1:0]  timer_mhz,
    input  logic [GIB_W-1:0]  mem_gib,
    output logic [DATA_W-1:0] value
);

    localparam int SIZE_W = 4;
    localparam int ONES_W = 12;
    localparam logic [FIELD_W-1:0] UNIT = FIELD_W'(1);

    logic [FIELD_W-1:0] mhz_f;
    logic [SIZE_W-1:0]  gib_f;
    logic [DATA_W-1:0]  clkdiv_w;
    logic [DATA_W-1:0]  memcfg_w;

    // Fit the live inputs into their field widths.
    always_comb begin
        mhz_f = FIELD_W'(timer_mhz);
        gib_f = SIZE_W'(mem_gib);
    end

    // Pack the divider and memory configuration words.
    always_comb begin
        clkdiv_w = {UNIT, UNIT, mhz_f, UNIT};
        memcfg_w = {{(DATA_W-ONES_W-SIZE_W){1'b0}}, {ONES_W{1'b1}}, gib_f};
    end

    // Choose the word for the selected register; others read as zero.
    always_comb begin
        case (sel)
            SEL_MEMSTAT:  value = MEMSTAT_VAL;
            SEL_CLKDIV:   value = clkdiv_w;
            SEL_BUILDCFG: value = BUILDCFG_VAL;
            SEL_MEMCFG:   value = memcfg_w;
            default:      value = '0;
        endcase
    end

endmodule

// File: rtl/plat_reset_trigger.sv
// Reset trigger: turns an accepted control write with the trigger bit set
// into a single registered request pulse. Stores no value.
// Assumes fire is already qualified by size and offset.
module plat_reset_trigger #(
    parameter int DATA_W  = 32,
    parameter int TRIG_BIT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic [DATA_W-1:0] wdata,
    output logic              pulse
);

    // Register the request for exactly the cycle after the write.
    always_ff @(posedge clk) begin
        if (!rst_n) pulse <= 1'b0;
        else        pulse <= fire && wdata[TRIG_BIT];
    end

endmodule

// File: rtl/plat_ctrl_regs.sv
// Platform status and control register bank (top).
// Decodes address bits [15:0], honours only 4-byte accesses, returns
// registered read data one cycle after a read, flags unimplemented
// accesses and issues a one-cycle system reset request.
// Assumes one request per cycle with no back-pressure.
module plat_ctrl_regs
    import plat_regs_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int MHZ_W  = 8,
    parameter int GIB_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [31:0]       req_wdata,
    input  logic [MHZ_W-1:0]  timer_mhz,
    input  logic [GIB_W-1:0]  mem_gib,
    output logic [31:0]       rdata,
    output logic              rd_valid,
    output logic              unimpl,
    output logic              sys_reset_req
);

    logic [OFF_W-1:0]  offset;
    reg_sel_e          sel;
    logic              rd_known;
    logic              wr_known;
    logic              word_ok;
    logic              rd_req;
    logic              wr_req;
    logic              rd_hit;
    logic              bad_acc;
    logic              fire;
    logic [DATA_W-1:0] rd_value;

    // Cut the decoded offset from the address.
    always_comb offset = req_addr[OFF_W-1:0];

    plat_addr_decode #(.DEC_W(OFF_W)) u_dec (
        .offset   (offset),
        .sel      (sel),
        .rd_known (rd_known),
        .wr_known (wr_known)
    );

    plat_status_mux #(.MHZ_W(MHZ_W), .GIB_W(GIB_W)) u_mux (
        .sel       (sel),
        .timer_mhz (timer_mhz),
        .mem_gib   (mem_gib),
        .value     (rd_value)
    );

    // Qualify the request by direction, size and decode.
    always_comb begin
        word_ok = (acc_size_e'(req_size) == SZ_WORD);
        rd_req  = req_valid && !req_write;
        wr_req  = req_valid && req_write;
        rd_hit  = rd_req && word_ok && rd_known;
        bad_acc = req_valid && (!word_ok || (req_write ? !wr_known : !rd_known));
        fire    = wr_req && word_ok && (sel == SEL_RSTCTL);
    end

    plat_reset_trigger #(.DATA_W(DATA_W), .TRIG_BIT(RST_BIT)) u_rst (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (fire),
        .wdata (req_wdata),
        .pulse (sys_reset_req)
    );

    // Register the read response; data updates only on reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata    <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_req;
            if (rd_req) rdata <= rd_hit ? rd_value : '0;
        end
    end

    // Register the one-cycle unimplemented-access flag.
    always_ff @(posedge clk) begin
        if (!rst_n) unimpl <= 1'b0;
        else        unimpl <= bad_acc;
    end

endmodule

// File: rtl/plat_ctrl_regs_chk.sv
// Checker for the platform register bank, bound to the top module.
// Relates the registered outputs to the request of the previous cycle.
module plat_ctrl_regs_chk #(
    parameter int ADDR_W = 32,
    parameter int MHZ_W  = 8,
    parameter int GIB_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [1:0]        req_size,
    input logic [31:0]       req_wdata,
    input logic [MHZ_W-1:0]  timer_mhz,
    input logic [GIB_W-1:0]  mem_gib,
    input logic [31:0]       rdata,
    input logic              rd_valid,
    input logic              unimpl,
    input logic              sys_reset_req
);

    logic [15:0] off;
    logic        word_rd;
    always_comb begin
        off     = req_addr[15:0];
        word_rd = req_valid && !req_write && (req_size == 2'd2);
    end

    AST_RESET_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        sys_reset_req |-> ($past(rst_n) && $past(req_valid && req_write && req_size == 2'd2
                           && off == 16'h0010 && req_wdata[4]))); // R7

    AST_RD_VALID_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (rd_valid == $past(req_valid && !req_write))); // R12

    AST_BAD_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(req_valid && req_size != 2'd2)) |->
        (unimpl && !sys_reset_req && (!rd_valid || rdata == 32'h0))); // R1

    AST_MEMSTAT_VAL: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(word_rd && off == 16'h0014)) |->
        (rdata == 32'h0000_0005 && !unimpl)); // R3

    AST_CLKDIV_PACK: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(word_rd && off == 16'h0030)) |->
        (rdata == {8'd1, 8'd1, 8'($past(timer_mhz)), 8'd1})); // R4

    AST_MEMCFG_PACK: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(word_rd && off == 16'h0038)) |->
        (rdata == {16'h0, 12'hFFF, 4'($past(mem_gib))})); // R6

    AST_ONEHOT_EVENTS: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sys_reset_req, rd_valid})); // R12

endmodule

bind plat_ctrl_regs plat_ctrl_regs_chk #(
    .ADDR_W(ADDR_W), .MHZ_W(MHZ_W), .GIB_W(GIB_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_write     (req_write),
    .req_addr      (req_addr),
    .req_size      (req_size),
    .req_wdata     (req_wdata),
    .timer_mhz     (timer_mhz),
    .mem_gib       (mem_gib),
    .rdata         (rdata),
    .rd_valid      (rd_valid),
    .unimpl        (unimpl),
    .sys_reset_req (sys_reset_req)
);

// File: tb/plat_ctrl_regs_tb.sv
// Scoreboard bench: the driver pushes the expected response of each cycle,
// and the monitor pops and compares it a quarter period after the edge.
module plat_ctrl_regs_tb;

    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_size = 2'd2;
    logic [31:0] req_wdata = '0;
    logic [7:0]  timer_mhz = 8'd100;
    logic [3:0]  mem_gib = 4'd2;
    logic [31:0] rdata;
    logic        rd_valid;
    logic        unimpl;
    logic        sys_reset_req;

    typedef struct {
        logic        rv;
        logic [31:0] rd;
        logic        un;
        logic        rst;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   n_run  = 0;
    int   n_fail = 0;
    bit   done   = 0;

    always #(PERIOD/2) clk = ~clk;

    plat_ctrl_regs u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .timer_mhz(timer_mhz), .mem_gib(mem_gib), .rdata(rdata),
        .rd_valid(rd_valid), .unimpl(unimpl), .sys_reset_req(sys_reset_req)
    );

    // Drive one access (or idle) and queue its expected response.
    task automatic cyc(input logic v, input logic w, input logic [31:0] a,
                       input logic [1:0] s, input logic [31:0] d,
                       input logic [31:0] erd, input logic eun,
                       input logic erst, input string tag);
        exp_t e;
        @(negedge clk);
        req_valid = v; req_write = w; req_addr = a; req_size = s; req_wdata = d;
        e.rv = v && !w; e.rd = erd; e.un = eun; e.rst = erst; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic rd(input logic [31:0] a, input logic [1:0] s,
                      input logic [31:0] erd, input logic eun, input string tag);
        cyc(1'b1, 1'b0, a, s, 32'h0, erd, eun, 1'b0, tag);
    endtask

    task automatic wr(input logic [31:0] a, input logic [1:0] s, input logic [31:0] d,
                      input logic eun, input logic erst, input string tag);
        cyc(1'b1, 1'b1, a, s, d, 32'h0, eun, erst, tag);
    endtask

    task automatic idle(input string tag);
        cyc(1'b0, 1'b0, 32'h0, 2'd2, 32'h0, 32'h0, 1'b0, 1'b0, tag);
    endtask

    // Monitor: compare outputs against the front of the queue.
    initial begin
        forever begin
            @(posedge clk);
            #(PERIOD/4);
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_run++;
                if (rd_valid !== e.rv || unimpl !== e.un || sys_reset_req !== e.rst ||
                    (e.rv && rdata !== e.rd)) begin
                    n_fail++;
                    $display("FAIL %s: got rv=%b rd=%h un=%b rst=%b exp rv=%b rd=%h un=%b rst=%b",
                             e.tag, rd_valid, rdata, unimpl, sys_reset_req,
                             e.rv, e.rd, e.un, e.rst);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(PERIOD * 100000);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: got hung exp finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #(PERIOD/4);
        n_run++;
        if (rdata !== 32'h0 || rd_valid !== 1'b0 || unimpl !== 1'b0 || sys_reset_req !== 1'b0) begin
            n_fail++;
            $display("FAIL R12 reset state: got rd=%h rv=%b un=%b rst=%b exp all zero",
                     rdata, rd_valid, unimpl, sys_reset_req);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R2 identifier words
        rd(32'h0000, 2'd2, 32'h0, 1'b0, "R2 id0");
        rd(32'h0004, 2'd2, 32'h0, 1'b0, "R2 id1");
        rd(32'h0008, 2'd2, 32'h0, 1'b0, "R2 id2");
        // R3, R5, R4, R6 status words
        rd(32'h0014, 2'd2, 32'h0000_0005, 1'b0, "R3 memstat");
        rd(32'h0034, 2'd2, 32'h0000_000E, 1'b0, "R5 buildcfg");
        rd(32'h0030, 2'd2, 32'h0101_6401, 1'b0, "R4 clkdiv 100MHz");
        rd(32'h0038, 2'd2, 32'h0000_FFF2, 1'b0, "R6 memcfg 2GiB");
        idle("R12 idle no valid");
        @(negedge clk); timer_mhz = 8'hFA; mem_gib = 4'd15;
        q.push_back('{rv:1'b0, rd:32'h0, un:1'b0, rst:1'b0, tag:"R12 idle"});
        rd(32'h0030, 2'd2, 32'h0101_FA01, 1'b0, "R4 clkdiv 250MHz");
        rd(32'h0038, 2'd2, 32'h0000_FFFF, 1'b0, "R6 memcfg 15GiB");
        // R11 upper address bits ignored
        rd(32'h17FF_0014, 2'd2, 32'h0000_0005, 1'b0, "R11 high bits memstat");
        rd(32'h0001_0030, 2'd2, 32'h0101_FA01, 1'b0, "R11 high bits clkdiv");
        // R1 size checks
        rd(32'h0014, 2'd0, 32'h0, 1'b1, "R1 byte read");
        rd(32'h0034, 2'd3, 32'h0, 1'b1, "R1 dword read");
        wr(32'h0010, 2'd1, 32'h0000_0010, 1'b1, 1'b0, "R1 half write no reset");
        // R7 reset pulse, then gone
        wr(32'h0010, 2'd2, 32'h0000_0010, 1'b0, 1'b1, "R7 reset write");
        idle("R7 pulse one cycle");
        // R8 bit clear
        wr(32'h0010, 2'd2, 32'hFFFF_FFEF, 1'b0, 1'b0, "R8 bit4 clear");
        // R9 read-only writes ignored
        wr(32'h0014, 2'd2, 32'hFFFF_FFFF, 1'b0, 1'b0, "R9 write memstat");
        wr(32'h0018, 2'd2, 32'hFFFF_FFFF, 1'b0, 1'b0, "R9 write linkstat");
        wr(32'h0034, 2'd2, 32'h0, 1'b0, 1'b0, "R9 write buildcfg");
        wr(32'h0000, 2'd2, 32'h1234_5678, 1'b0, 1'b0, "R9 write id0");
        rd(32'h0014, 2'd2, 32'h0000_0005, 1'b0, "R9 memstat unchanged");
        rd(32'h0034, 2'd2, 32'h0000_000E, 1'b0, "R9 buildcfg unchanged");
        rd(32'h0000, 2'd2, 32'h0, 1'b0, "R9 id0 unchanged");
        // R10 undecoded
        rd(32'h003C, 2'd2, 32'h0, 1'b1, "R10 read 0x3c");
        rd(32'h0010, 2'd2, 32'h0, 1'b1, "R10 read ctl");
        rd(32'h0018, 2'd2, 32'h0, 1'b1, "R10 read linkstat");
        wr(32'h0020, 2'd2, 32'hFFFF_FFFF, 1'b1, 1'b0, "R10 write 0x20");
        wr(32'h0FFC, 2'd2, 32'h0000_0010, 1'b1, 1'b0, "R10 write 0xffc");
        idle("R12 drain");
        idle("R12 drain");
        repeat (3) @(posedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule